// File: doc/BRIEF.md
# Indexed Interrupt Redirection Unit

The unit routes up to 24 interrupt input lines to processor-side interrupt controllers. Every line owns a 64-bit steering entry. The entry holds the vector, the delivery mode, the destination mode, the polarity, the trigger style, a mask bit and an 8-bit destination. Software never addresses the entries directly. It writes an index into a selector register and then moves 32-bit words through a single data window. Each entry therefore spans two consecutive index values.

Each line keeps a pending flag. Edge lines latch the flag on a rising input, and only a dispatch clears it. Level lines mirror the input. Whenever a line is pending, unmasked and armed for service, a scan picks the lowest such line. It copies that line's entry into a delivery message, and the message is offered on a valid/ready handshake. Physical input 0 feeds line 2, which matches the usual wiring of a system timer. Decoding a destination into a set of processors is left to the receiver.

Top module: `iru_top`

## Requirements
- R1: Bus offset 0x00 is the 8-bit selector register, readable in bits 7:0. Offset 0x10 is the data window. Every other offset reads 0, and writes to it change nothing.
- R2: Through the window, selector 0 gives the unit ID in bits 31:24, and only those bits can be written. Selector 1 reads 0x00170011, which is the highest entry number 23 in bits 23:16 and 0x11 in bits 7:0. Selector 2 reads 0. Writes to selectors 1 and 2 are ignored.
- R3: Entry n sits at selector 0x10+2n for bits 31:0 and at 0x11+2n for bits 63:32, and both halves can be read and written in full. Selectors 3 to 0x0F and from 0x40 upward read 0 and ignore writes.
- R4: After reset every entry reads 0x0000_0000_0001_0000 (masked). The ID and the selector are 0, no line is pending and no message is valid.
- R5: An entry holds the vector in bits 7:0, the delivery mode in 10:8, the destination mode in 11, the polarity in 13 (stored only), the trigger style in 15 (1 = level), the mask in 16 and the destination in 63:56. A message carries the destination, destination mode, delivery mode, vector and trigger bit that the entry holds on the cycle it is dispatched.
- R6: Physical input 0 drives line 2, ORed with physical input 2. Line 0 never becomes pending.
- R7: On an edge line, a rising input sets the pending flag, and only that line's dispatch clears it. A line held high yields exactly one message per rising edge.
- R8: On a level line, the pending flag follows the input, and a dispatch leaves it set. A line held high sends one message per arming event (a rise or an entry write), and a low line sends none.
- R9: A masked line stays pending and sends nothing. Once an entry write unmasks it, it is dispatched.
- R10: Writing either half of any entry re-arms every line, so that all pending, unmasked lines are served again.
- R11: When several lines are eligible, the lowest-numbered one goes first, and at most one message is accepted per cycle.
- R12: While valid is high and ready is low, valid stays high and every message field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register offset |
| busWr | input | 1 | Write strobe for busWdata |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irqIn | input | NUM_LINES | Physical interrupt inputs, active high |
| msgValid | output | 1 | Delivery message valid |
| msgReady | input | 1 | Receiver accepts the message |
| msgDest | output | 8 | Destination |
| msgDestMode | output | 1 | Destination mode |
| msgDelivMode | output | 3 | Delivery mode |
| msgVector | output | 8 | Vector |
| msgTrigLevel | output | 1 | 1 for a level-triggered source |

## Verification
Several properties are checked on every cycle. A stalled message stays frozen with valid held. A dispatch never selects a masked entry, and it never passes over a lower eligible line. Line 0 stays idle. An edge flag keeps its value until its own dispatch and drops right after it. Other behaviour can only be shown by the bench's scenarios, which compare every accepted message against the expected one. These are the register map read-backs, the field packing of messages, the remapping of input 0, the count of one message per edge or per arming event on a held level line, release on unmask, and the ordering of messages that arrive together.

// File: rtl/iru_pkg.sv
package iru_pkg;

  // Bus offsets
  localparam logic [7:0] ADDR_SELECT = 8'h00;
  localparam logic [7:0] ADDR_WINDOW = 8'h10;

  // Selector values below the entry range
  localparam logic [7:0] SEL_ID      = 8'h00;
  localparam logic [7:0] SEL_VERSION = 8'h01;
  localparam logic [7:0] SEL_ARB     = 8'h02;
  localparam logic [7:0] SEL_ENTRY0  = 8'h10;
  localparam logic [7:0] VERSION_LO  = 8'h11;

  // Steering-entry field positions
  localparam int F_VEC_LO  = 0;
  localparam int F_DLV_LO  = 8;
  localparam int F_DMODE   = 11;
  localparam int F_POL     = 13;
  localparam int F_TRIG    = 15;
  localparam int F_MASK    = 16;
  localparam int F_DEST_LO = 56;

  localparam logic [63:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

  typedef struct packed {
    logic [7:0] dest;
    logic       destMode;
    logic [2:0] delivMode;
    logic [7:0] vector;
    logic       trigLevel;
  } iru_msg_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic       load;
    logic [7:0] line;
  } iru_ctrl_t;

endpackage

// File: rtl/iru_line_cond.sv
module iru_line_cond #(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic [NUM_LINES-1:0] effLine,
  output logic [NUM_LINES-1:0] riseLine
);

  localparam int REMAP_SRC = 0;
  localparam int REMAP_DST = 2;

  logic [NUM_LINES-1:0] prevLine;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    if (g == REMAP_SRC) begin : g_src
      assign effLine[g] = 1'b0;
    end else if (g == REMAP_DST) begin : g_dst
      assign effLine[g] = irqIn[g] | irqIn[REMAP_SRC];
    end else begin : g_plain
      assign effLine[g] = irqIn[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevLine <= '0;
    else       prevLine <= effLine;
  end

  assign riseLine = effLine & ~prevLine;

endmodule

// File: rtl/iru_datapath.sv
module iru_datapath
  import iru_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           busAddr,
  input  logic                 busWr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_LINES-1:0] effLine,
  input  logic [NUM_LINES-1:0] riseLine,
  input  iru_ctrl_t            ctrl,
  output logic [NUM_LINES-1:0] eligible,
  output logic                 entryWrite,
  output iru_msg_t             msg
);

  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int SEL_LIMIT = 16 + 2 * NUM_LINES;
  localparam logic [31:0] VERSION_WORD = {8'h00, 8'(NUM_LINES - 1), 8'h00, VERSION_LO};

  logic [7:0]           selectReg;
  logic [7:0]           unitId;
  logic [63:0]          entryMem [NUM_LINES];
  logic [NUM_LINES-1:0] pendingQ;

  logic             hitSelect, hitWindow, inRange;
  logic [7:0]       entryOff;
  logic [IDX_W-1:0] entrySel, loadSel;

  assign hitSelect  = (busAddr == ADDR_SELECT);
  assign hitWindow  = (busAddr == ADDR_WINDOW);
  assign entryOff   = selectReg - SEL_ENTRY0;
  assign inRange    = (selectReg >= SEL_ENTRY0) && (int'(selectReg) < SEL_LIMIT);
  assign entrySel   = IDX_W'(entryOff >> 1);
  assign loadSel    = ctrl.line[IDX_W-1:0];
  assign entryWrite = busWr && hitWindow && inRange;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selectReg <= '0;
      unitId    <= '0;
    end else begin
      if (busWr && hitSelect) selectReg <= busWdata[7:0];
      if (busWr && hitWindow && selectReg == SEL_ID) unitId <= busWdata[31:24];
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryMem[g] <= ENTRY_RESET;
      end else if (entryWrite && entrySel == IDX_W'(g)) begin
        if (selectReg[0]) entryMem[g][63:32] <= busWdata;
        else              entryMem[g][31:0]  <= busWdata;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)                                  pendingQ[g] <= 1'b0;
      else if (entryMem[g][F_TRIG])               pendingQ[g] <= effLine[g];
      else if (riseLine[g])                       pendingQ[g] <= 1'b1;
      else if (ctrl.load && ctrl.line == 8'(g))   pendingQ[g] <= 1'b0;
    end

    assign eligible[g] = pendingQ[g] & ~entryMem[g][F_MASK];

    // R7: an edge flag survives until its own dispatch
    p_edge_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
      (pendingQ[g] && !entryMem[g][F_TRIG] && !entryWrite &&
       !(ctrl.load && ctrl.line == 8'(g))) |=> pendingQ[g]);

    // R7: dispatch of an edge line without a new rise drops its flag
    p_edge_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
      (ctrl.load && ctrl.line == 8'(g) && !entryMem[g][F_TRIG] &&
       !riseLine[g] && !entryWrite) |=> !pendingQ[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msg <= '0;
    end else if (ctrl.load) begin
      msg.dest      <= entryMem[loadSel][F_DEST_LO +: 8];
      msg.destMode  <= entryMem[loadSel][F_DMODE];
      msg.delivMode <= entryMem[loadSel][F_DLV_LO +: 3];
      msg.vector    <= entryMem[loadSel][F_VEC_LO +: 8];
      msg.trigLevel <= entryMem[loadSel][F_TRIG];
    end
  end

  always_comb begin
    busRdata = '0;
    if (hitSelect) begin
      busRdata = {24'h0, selectReg};
    end else if (hitWindow) begin
      if (selectReg == SEL_ID)           busRdata = {unitId, 24'h0};
      else if (selectReg == SEL_VERSION) busRdata = VERSION_WORD;
      else if (selectReg == SEL_ARB)     busRdata = '0;
      else if (inRange)
        busRdata = selectReg[0] ? entryMem[entrySel][63:32] : entryMem[entrySel][31:0];
    end
  end

  // R9: the scan never picks a masked entry
  p_no_masked_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |-> !entryMem[loadSel][F_MASK]);

  // R6: line 0 has no source after the remap
  p_line0_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !pendingQ[0]);

endmodule

// File: rtl/iru_control.sv
module iru_control
  import iru_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] eligible,
  input  logic [NUM_LINES-1:0] riseLine,
  input  logic                 entryWrite,
  input  logic                 msgReady,
  output iru_ctrl_t            ctrl,
  output logic                 msgValid
);

  logic [NUM_LINES-1:0] armedQ, armedNext, cand, clrMask;
  logic                 hit;
  logic [7:0]           pickLine;
  logic                 slotFree;

  assign cand = eligible & armedQ;

  always_comb begin
    hit      = 1'b0;
    pickLine = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit      = 1'b1;
        pickLine = 8'(i);
      end
    end
  end

  assign slotFree  = !msgValid || msgReady;
  assign ctrl.load = slotFree && hit;
  assign ctrl.line = pickLine;

  assign clrMask   = ctrl.load ? (NUM_LINES'(1) << ctrl.line) : '0;
  assign armedNext = (armedQ & ~clrMask) | riseLine | {NUM_LINES{entryWrite}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ   <= '0;
      msgValid <= 1'b0;
    end else begin
      armedQ <= armedNext;
      if (ctrl.load)     msgValid <= 1'b1;
      else if (msgReady) msgValid <= 1'b0;
    end
  end

  // R11: no armed eligible line below the one picked
  p_lowest_first_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |-> ((cand & ((NUM_LINES'(1) << ctrl.line) - NUM_LINES'(1))) == '0));

  // R12: a stalled message stays valid
  p_valid_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> msgValid);

endmodule

// File: rtl/iru_top.sv
module iru_top
  import iru_pkg::*;
#(
  parameter int NUM_LINES = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           busAddr,
  input  logic                 busWr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic                 msgValid,
  input  logic                 msgReady,
  output logic [7:0]           msgDest,
  output logic                 msgDestMode,
  output logic [2:0]           msgDelivMode,
  output logic [7:0]           msgVector,
  output logic                 msgTrigLevel
);

  iru_ctrl_t            ctrl;
  iru_msg_t             msg;
  logic [NUM_LINES-1:0] effLine, riseLine, eligible;
  logic                 entryWrite;

  iru_line_cond #(.NUM_LINES(NUM_LINES)) u_cond (
    .clk      (clk),
    .rstN     (rstN),
    .irqIn    (irqIn),
    .effLine  (effLine),
    .riseLine (riseLine)
  );

  iru_datapath #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWr      (busWr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .effLine    (effLine),
    .riseLine   (riseLine),
    .ctrl       (ctrl),
    .eligible   (eligible),
    .entryWrite (entryWrite),
    .msg        (msg)
  );

  iru_control #(.NUM_LINES(NUM_LINES)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .eligible   (eligible),
    .riseLine   (riseLine),
    .entryWrite (entryWrite),
    .msgReady   (msgReady),
    .ctrl       (ctrl),
    .msgValid   (msgValid)
  );

  assign msgDest      = msg.dest;
  assign msgDestMode  = msg.destMode;
  assign msgDelivMode = msg.delivMode;
  assign msgVector    = msg.vector;
  assign msgTrigLevel = msg.trigLevel;

  // R12: message fields frozen during a stall
  p_msg_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> $stable(msg));

endmodule

// File: tb/iru_top_bench.sv
module iru_top_bench;
  import iru_pkg::*;

  localparam int NL = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    busAddr = '0;
  logic          busWr = 1'b0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NL-1:0] irqIn = '0;
  logic          msgValid;
  logic          msgReady = 1'b1;
  logic [7:0]    msgDest;
  logic          msgDestMode;
  logic [2:0]    msgDelivMode;
  logic [7:0]    msgVector;
  logic          msgTrigLevel;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;
  iru_msg_t sbQ[$];

  always #4 clk = ~clk;

  iru_top #(.NUM_LINES(NL)) u_iru_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irqIn(irqIn),
    .msgValid(msgValid), .msgReady(msgReady), .msgDest(msgDest),
    .msgDestMode(msgDestMode), .msgDelivMode(msgDelivMode),
    .msgVector(msgVector), .msgTrigLevel(msgTrigLevel)
  );

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] v);
    @(posedge clk); #1;
    busAddr = a; busWdata = v; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    busAddr = a; busWr = 1'b0;
    @(negedge clk);
    d = busRdata;
  endtask

  task automatic selRead(input logic [7:0] sel, output logic [31:0] d);
    busWrite(8'h00, {24'h0, sel});
    busRead(8'h10, d);
  endtask

  task automatic selWrite(input logic [7:0] sel, input logic [31:0] v);
    busWrite(8'h00, {24'h0, sel});
    busWrite(8'h10, v);
  endtask

  task automatic entryWr(input int n, input logic [31:0] lo, input logic [31:0] hi);
    selWrite(8'(16 + 2 * n + 1), hi);
    selWrite(8'(16 + 2 * n), lo);
  endtask

  // Scoreboard driver: expected message from the entry words (R5 layout)
  task automatic expectMsg(input logic [31:0] lo, input logic [31:0] hi);
    iru_msg_t m;
    m.dest      = hi[31:24];
    m.destMode  = lo[11];
    m.delivMode = lo[10:8];
    m.vector    = lo[7:0];
    m.trigLevel = lo[15];
    sbQ.push_back(m);
  endtask

  task automatic pulse(input int b);
    @(posedge clk); #1 irqIn[b] = 1'b1;
    @(posedge clk); #1 irqIn[b] = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && msgValid && msgReady) begin
      iru_msg_t got;
      got = '{dest: msgDest, destMode: msgDestMode, delivMode: msgDelivMode,
              vector: msgVector, trigLevel: msgTrigLevel};
      if (sbQ.size() == 0) begin
        nChecks++;
        nFail++;
        $display("FAIL R7 R8 R11 unexpected message: actual 0x%06h expected none", got);
      end else begin
        iru_msg_t exp;
        exp = sbQ.pop_front();
        checkEq("R5 message fields", 32'(got), 32'(exp));
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v1, v2;
    waitCycles(3);
    #1 rstN = 1'b1;

    // R4 reset state
    checkEq("R4 valid after reset", 32'(msgValid), 32'h0);
    busRead(8'h00, d);   checkEq("R4 selector reset", d, 32'h0);
    busRead(8'h10, d);   checkEq("R4 ID reset", d, 32'h0);
    selRead(8'h10, d);   checkEq("R4 entry0 low reset", d, 32'h0001_0000);
    selRead(8'h3F, d);   checkEq("R4 entry23 high reset", d, 32'h0);

    // R1 selector and unused offsets
    busWrite(8'h00, 32'hFFFF_FF2A);
    busRead(8'h00, d);   checkEq("R1 selector readback", d, 32'h0000_002A);
    busWrite(8'h20, 32'h0000_0055);
    busRead(8'h20, d);   checkEq("R1 unused offset reads 0", d, 32'h0);
    busRead(8'h00, d);   checkEq("R1 unused offset write ignored", d, 32'h0000_002A);

    // R2 ID / version / arbitration words
    selWrite(8'h00, 32'hAABB_CCDD);
    busRead(8'h10, d);   checkEq("R2 ID only top byte", d, 32'hAA00_0000);
    selWrite(8'h01, 32'hFFFF_FFFF);
    busRead(8'h10, d);   checkEq("R2 version word", d, 32'h0017_0011);
    selWrite(8'h02, 32'hFFFF_FFFF);
    busRead(8'h10, d);   checkEq("R2 selector 2 reads 0", d, 32'h0);

    // R3 entry halves and out-of-range selectors
    selWrite(8'h3F, 32'h1234_5678);
    busRead(8'h10, d);   checkEq("R3 entry23 high rw", d, 32'h1234_5678);
    selWrite(8'h05, 32'hFFFF_FFFF);
    busRead(8'h10, d);   checkEq("R3 selector 5 reads 0", d, 32'h0);
    selWrite(8'h40, 32'hFFFF_FFFF);
    busRead(8'h10, d);   checkEq("R3 selector 0x40 reads 0", d, 32'h0);
    selRead(8'h3F, d);   checkEq("R3 entry23 untouched", d, 32'h1234_5678);
    selRead(8'h3E, d);   checkEq("R3 entry23 low still masked", d, 32'h0001_0000);

    // R7 edge line 5, R5 field packing
    entryWr(5, 32'h0000_0835, 32'h0A00_0000);
    selRead(8'h1A, d);   checkEq("R5 entry5 low readback", d, 32'h0000_0835);
    expectMsg(32'h0000_0835, 32'h0A00_0000);
    pulse(5);
    waitCycles(8);
    checkEq("R7 edge message drained", sbQ.size(), 0);
    expectMsg(32'h0000_0835, 32'h0A00_0000);
    @(posedge clk); #1 irqIn[5] = 1'b1;
    waitCycles(20);
    @(posedge clk); #1 irqIn[5] = 1'b0;
    checkEq("R7 one message per held edge", sbQ.size(), 0);

    // R6 input 0 drives line 2; entry 0 stays silent
    entryWr(0, 32'h0000_0010, 32'h0100_0000);
    entryWr(2, 32'h0000_2422, 32'hFF00_0000);
    expectMsg(32'h0000_2422, 32'hFF00_0000);
    pulse(0);
    waitCycles(8);
    checkEq("R6 input0 to line2", sbQ.size(), 0);

    // R8 level line 7, R10 re-arm on entry write
    entryWr(7, 32'h0000_8147, 32'h0300_0000);
    expectMsg(32'h0000_8147, 32'h0300_0000);
    @(posedge clk); #1 irqIn[7] = 1'b1;
    waitCycles(15);
    checkEq("R8 level held sends once", sbQ.size(), 0);
    expectMsg(32'h0000_8147, 32'h0300_0000);
    selWrite(8'h1F, 32'h0300_0000);
    waitCycles(8);
    checkEq("R10 entry write re-arms level line", sbQ.size(), 0);
    @(posedge clk); #1 irqIn[7] = 1'b0;
    waitCycles(2);
    selWrite(8'h1F, 32'h0300_0000);
    waitCycles(8);
    checkEq("R8 low level line silent", sbQ.size(), 0);

    // R9 masked edge line 9 kept pending, released on unmask
    entryWr(9, 32'h0001_0059, 32'h0000_0000);
    pulse(9);
    waitCycles(10);
    expectMsg(32'h0000_0059, 32'h0000_0000);
    selWrite(8'h22, 32'h0000_0059);
    waitCycles(8);
    checkEq("R9 unmask releases pending", sbQ.size(), 0);

    // R11 ordering, R12 stall hold
    entryWr(3, 32'h0000_0033, 32'h0200_0000);
    entryWr(4, 32'h0000_0044, 32'h0400_0000);
    @(posedge clk); #1 msgReady = 1'b0;
    expectMsg(32'h0000_0033, 32'h0200_0000);
    expectMsg(32'h0000_0044, 32'h0400_0000);
    @(posedge clk); #1 irqIn[3] = 1'b1; irqIn[4] = 1'b1;
    @(posedge clk); #1 irqIn[3] = 1'b0; irqIn[4] = 1'b0;
    waitCycles(5);
    @(negedge clk);
    v1 = {23'h0, msgValid, msgVector};
    waitCycles(3);
    @(negedge clk);
    v2 = {23'h0, msgValid, msgVector};
    checkEq("R12 stalled message valid and lowest line", v1, 32'h0000_0133);
    checkEq("R12 stalled message stable", v2, v1);
    @(posedge clk); #1 msgReady = 1'b1;
    waitCycles(10);
    checkEq("R11 both messages in order", sbQ.size(), 0);

    waitCycles(10);
    checkEq("R11 scoreboard drained", sbQ.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule